// File: doc/BRIEF.md
# Dual ADC Conversion Sequencer

This block steps a shared two-input sample-and-hold converter through a programmed list of channel selects and stores the codes it returns in a bank of result registers. Sixteen 4-bit select slots come in on a flat configuration port. The slots can be driven by two independent sequencers of eight slots each or by one cascaded sequencer that owns all sixteen. The converter is reached through a request/done handshake. The block presents a channel select and holds a request. The converter answers with a done pulse and two 12-bit codes, one for each input of the selected pair.

Sampling is either sequential or simultaneous. In sequential mode each slot converts one of sixteen inputs and fills one result register. In simultaneous mode each slot converts both members of an input pair and fills two result registers. Each sequencer keeps its slot pointer from one triggered run to the next. Software can clear a pointer, and each sequencer reports the end of a run with a one-cycle flag.

The configuration inputs are expected to stay constant while a run is in progress.

Top module: `adc_dual_seq`

## Requirements
- R1: After reset, every result register reads 0, `adc_req`, both busy outputs and both end-of-run flags are low, and both pointers read 0.
- R2: In dual mode, sequencer 1 uses slots 0 to 7 and sequencer 2 uses slots 8 to 15. A count field value of N gives N+1 conversions per triggered run. Sequencer 1 uses the low 3 bits of `cfg_cnt1`, and sequencer 2 uses `cfg_cnt2`.
- R3: In sequential mode, the 4-bit slot select is sent unchanged on `adc_chan`. The stored code is `adc_code_b` when select bit 3 is 1 and `adc_code_a` when it is 0. It is written to the result register whose index equals the slot number.
- R4: In simultaneous mode, select bit 3 is ignored and `adc_chan[3]` reads 0 during a request. For run position j, the A code goes to result (base + 2j) mod 16 and the B code to the next register. The base is 0 for sequencer 1 and 8 for sequencer 2. In sequencer 1, j is the slot number; in sequencer 2, j is the pointer value.
- R5: A pointer is not cleared when a run ends. The next trigger continues from the following slot. The pointer wraps within the sequencer's own slot range.
- R6: A pulse on `ptr_clr1` or `ptr_clr2` sets that sequencer's pointer to 0.
- R7: `trig_a` starts sequencer 1 only when `cfg_trig_a_en` is 1. `trig_b` starts sequencer 2 only when `cfg_trig_b_en` is 1. In cascaded mode `trig_b` has no effect.
- R8: In cascaded mode, sequencer 1 walks all 16 slots and uses all 4 bits of `cfg_cnt1` as its count.
- R9: A trigger that arrives while the converter is busy is held pending and served once the current run ends. When both sequencers are pending, sequencer 1 runs first.
- R10: A sequencer's end-of-run output is high for exactly one cycle. That cycle immediately follows the clock edge that stores the last result of the run.
- R11: In continuous mode, the end of a run resets the pointer to 0 and starts the next run at once, without a trigger. When continuous mode is cleared, the run in progress completes and the sequencer stops.
- R12: While `adc_req` is high and `adc_done` is low, `adc_req` stays high on the next cycle and `adc_chan` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cascade | input | 1 | 1 = one 16-slot sequencer, 0 = two 8-slot sequencers |
| cfg_simul | input | 1 | 1 = simultaneous pair sampling, 0 = sequential |
| cfg_contin | input | 1 | 1 = continuous run, 0 = start/stop |
| cfg_trig_a_en | input | 1 | Lets `trig_a` start sequencer 1 |
| cfg_trig_b_en | input | 1 | Lets `trig_b` start sequencer 2 |
| cfg_cnt1 | input | 4 | Sequencer 1 conversions minus one |
| cfg_cnt2 | input | 3 | Sequencer 2 conversions minus one |
| cfg_slots | input | 64 | Slot k select in bits [4k+3:4k] |
| trig_a | input | 1 | Start pulse for sequencer 1 |
| trig_b | input | 1 | Start pulse for sequencer 2 |
| ptr_clr1 | input | 1 | Clears sequencer 1 pointer |
| ptr_clr2 | input | 1 | Clears sequencer 2 pointer |
| adc_req | output | 1 | Conversion request to the converter |
| adc_chan | output | 4 | Channel or pair select for the request |
| adc_done | input | 1 | Converter finished the current request |
| adc_code_a | input | 12 | Code of the A input of the selected pair |
| adc_code_b | input | 12 | Code of the B input of the selected pair |
| results | output | 192 | Result register k in bits [12k+11:12k] |
| seq1_ptr | output | 4 | Sequencer 1 slot pointer |
| seq2_ptr | output | 3 | Sequencer 2 slot pointer (slot = 8 + value) |
| seq1_busy | output | 1 | Sequencer 1 owns the converter |
| seq2_busy | output | 1 | Sequencer 2 owns the converter |
| seq1_eos | output | 1 | Sequencer 1 end-of-run flag |
| seq2_eos | output | 1 | Sequencer 2 end-of-run flag |

## Verification
The embedded properties check the following on every cycle:
- the handshake holds the request and the channel select steady until done;
- the top select bit is masked in simultaneous mode;
- a simultaneous write always starts at an even register;
- an end-of-run flag only follows a completed conversion;
- an idle pointer does not move;
- sequencer 2 never takes the converter in cascaded mode;
- sequencer 2 stays pending while sequencer 1 is chosen first.

Other behaviours can only be shown by the bench scenarios:
- where each code lands in the result bank;
- how a pointer carries over and wraps across successive runs;
- a trigger that is queued behind a busy run;
- the priority ordering when both sequencers are pending, visible as which code overwrites a shared register;
- continuous restarts.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_S1   = 2'd1,
    OWN_S2   = 2'd2
  } owner_t;
endpackage

// File: rtl/adcseq_trig.sv
module adcseq_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic cascade,
  input  logic idle,
  input  logic req1,
  input  logic req2,
  output logic grant1,
  output logic grant2
);
  logic p1_q, p2_q;

  // sequencer 1 wins when both wait
  assign grant1 = idle & p1_q;
  assign grant2 = idle & p2_q & ~p1_q & ~cascade;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p1_q <= 1'b0;
      p2_q <= 1'b0;
    end else begin
      p1_q <= (p1_q & ~grant1) | req1;
      p2_q <= cascade ? 1'b0 : ((p2_q & ~grant2) | req2);
    end
  end

  AST_SEQ1_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && p1_q && p2_q && !cascade) |=> p2_q); // R9
endmodule

// File: rtl/adcseq_ptr.sv
module adcseq_ptr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         restart,
  input  logic         step,
  input  logic         wide,
  output logic [W-1:0] ptr
);
  logic [W-1:0] ptr_q;

  function automatic logic [W-1:0] ptr_after(input logic [W-1:0] p, input logic full);
    logic [W-2:0] low;
    low = p[W-2:0] + 1'b1;
    return full ? p + 1'b1 : {1'b0, low};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)              ptr_q <= '0;
    else if (clr || restart) ptr_q <= '0;
    else if (step)           ptr_q <= ptr_after(ptr_q, wide);
  end

  assign ptr = ptr_q;

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr || restart || step) |=> $stable(ptr_q)); // R5
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ptr_q == '0); // R6
endmodule

// File: rtl/adcseq_bank.sv
module adcseq_bank #(
  parameter int SLOTS  = 16,
  parameter int CODE_W = 12,
  parameter int IDX_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic                      pair,
  input  logic [IDX_W-1:0]          idx,
  input  logic [CODE_W-1:0]         din_a,
  input  logic [CODE_W-1:0]         din_b,
  output logic [SLOTS*CODE_W-1:0]   bank
);
  logic [IDX_W-1:0] idx_odd;
  assign idx_odd = {idx[IDX_W-1:1], 1'b1};

  for (genvar i = 0; i < SLOTS; i++) begin : g_reg
    logic [CODE_W-1:0] r_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                   r_q <= '0;
      else if (we && idx == IDX_W'(i))              r_q <= din_a;
      else if (we && pair && idx_odd == IDX_W'(i))  r_q <= din_b;
    end
    assign bank[i*CODE_W +: CODE_W] = r_q;
  end

  AST_PAIR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (we && pair) |-> !idx[0]); // R4
endmodule

// File: rtl/adc_dual_seq.sv
module adc_dual_seq
  import adcseq_pkg::*;
#(
  parameter int SLOTS  = 16,
  parameter int CH_W   = 4,
  parameter int CODE_W = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_cascade,
  input  logic                       cfg_simul,
  input  logic                       cfg_contin,
  input  logic                       cfg_trig_a_en,
  input  logic                       cfg_trig_b_en,
  input  logic [$clog2(SLOTS)-1:0]   cfg_cnt1,
  input  logic [$clog2(SLOTS)-2:0]   cfg_cnt2,
  input  logic [SLOTS*CH_W-1:0]      cfg_slots,
  input  logic                       trig_a,
  input  logic                       trig_b,
  input  logic                       ptr_clr1,
  input  logic                       ptr_clr2,
  output logic                       adc_req,
  output logic [CH_W-1:0]            adc_chan,
  input  logic                       adc_done,
  input  logic [CODE_W-1:0]          adc_code_a,
  input  logic [CODE_W-1:0]          adc_code_b,
  output logic [SLOTS*CODE_W-1:0]    results,
  output logic [$clog2(SLOTS)-1:0]   seq1_ptr,
  output logic [$clog2(SLOTS)-2:0]   seq2_ptr,
  output logic                       seq1_busy,
  output logic                       seq2_busy,
  output logic                       seq1_eos,
  output logic                       seq2_eos
);
  localparam int PTR_W  = $clog2(SLOTS);
  localparam int HPTR_W = PTR_W - 1;
  localparam int HALF   = SLOTS / 2;
  localparam int IDX_W  = PTR_W + 1;

  owner_t             owner_q;
  logic [PTR_W-1:0]   rem_q;
  logic               req_q, eos1_q, eos2_q;

  // named internal events
  logic               idle, grant1, grant2, conv_fire, run_last;
  logic               start1_ok, start2_ok, restart1, restart2;
  logic [PTR_W-1:0]   ptr1, slot, run_pos, wr_idx;
  logic [HPTR_W-1:0]  ptr2;
  logic [CH_W-1:0]    sel;
  logic [CODE_W-1:0]  wr_a;

  function automatic logic [PTR_W-1:0] slot_of(input owner_t own, input logic casc,
                                               input logic [PTR_W-1:0] p1,
                                               input logic [HPTR_W-1:0] p2);
    if (own == OWN_S2) return PTR_W'(HALF) + {1'b0, p2};
    if (casc)          return p1;
    return {1'b0, p1[HPTR_W-1:0]};
  endfunction

  function automatic logic [PTR_W-1:0] pair_idx(input owner_t own, input logic [PTR_W-1:0] j);
    logic [IDX_W-1:0] t;
    t = {j, 1'b0} + ((own == OWN_S2) ? IDX_W'(HALF) : IDX_W'(0));
    return t[PTR_W-1:0];
  endfunction

  function automatic logic [PTR_W-1:0] run_len(input owner_t own, input logic casc,
                                               input logic [PTR_W-1:0] c1,
                                               input logic [HPTR_W-1:0] c2);
    if (own == OWN_S2) return {1'b0, c2};
    if (casc)          return c1;
    return {1'b0, c1[HPTR_W-1:0]};
  endfunction

  assign idle      = (owner_q == OWN_NONE);
  assign conv_fire = req_q & adc_done;
  assign run_last  = (rem_q == '0);
  assign start1_ok = trig_a & cfg_trig_a_en;
  assign start2_ok = trig_b & cfg_trig_b_en & ~cfg_cascade;
  assign restart1  = conv_fire & run_last & cfg_contin & (owner_q == OWN_S1);
  assign restart2  = conv_fire & run_last & cfg_contin & (owner_q == OWN_S2);

  assign slot    = slot_of(owner_q, cfg_cascade, ptr1, ptr2);
  assign run_pos = (owner_q == OWN_S2) ? {1'b0, ptr2} : slot;
  assign sel     = cfg_slots[slot*CH_W +: CH_W];
  assign wr_idx  = cfg_simul ? pair_idx(owner_q, run_pos) : slot;
  assign wr_a    = (cfg_simul || !sel[CH_W-1]) ? adc_code_a : adc_code_b;

  adcseq_trig u_trig (
    .clk(clk), .rst_n(rst_n), .cascade(cfg_cascade), .idle(idle),
    .req1(start1_ok), .req2(start2_ok), .grant1(grant1), .grant2(grant2)
  );

  adcseq_ptr #(.W(PTR_W)) u_ptr1 (
    .clk(clk), .rst_n(rst_n), .clr(ptr_clr1), .restart(restart1),
    .step(conv_fire && owner_q == OWN_S1), .wide(cfg_cascade), .ptr(ptr1)
  );

  adcseq_ptr #(.W(HPTR_W)) u_ptr2 (
    .clk(clk), .rst_n(rst_n), .clr(ptr_clr2), .restart(restart2),
    .step(conv_fire && owner_q == OWN_S2), .wide(1'b1), .ptr(ptr2)
  );

  adcseq_bank #(.SLOTS(SLOTS), .CODE_W(CODE_W), .IDX_W(PTR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(conv_fire), .pair(cfg_simul), .idx(wr_idx),
    .din_a(wr_a), .din_b(adc_code_b), .bank(results)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q <= OWN_NONE;
      rem_q   <= '0;
      req_q   <= 1'b0;
      eos1_q  <= 1'b0;
      eos2_q  <= 1'b0;
    end else begin
      eos1_q <= conv_fire & run_last & (owner_q == OWN_S1);
      eos2_q <= conv_fire & run_last & (owner_q == OWN_S2);
      if (idle) begin
        if (grant1 || grant2) begin
          owner_q <= grant1 ? OWN_S1 : OWN_S2;
          rem_q   <= run_len(grant1 ? OWN_S1 : OWN_S2, cfg_cascade, cfg_cnt1, cfg_cnt2);
          req_q   <= 1'b1;
        end
      end else if (conv_fire) begin
        if (!run_last)       rem_q <= rem_q - 1'b1;
        else if (cfg_contin) rem_q <= run_len(owner_q, cfg_cascade, cfg_cnt1, cfg_cnt2);
        else begin
          owner_q <= OWN_NONE;
          req_q   <= 1'b0;
        end
      end
    end
  end

  assign adc_req   = req_q;
  assign adc_chan  = cfg_simul ? {1'b0, sel[CH_W-2:0]} : sel;
  assign seq1_ptr  = ptr1;
  assign seq2_ptr  = ptr2;
  assign seq1_busy = (owner_q == OWN_S1);
  assign seq2_busy = (owner_q == OWN_S2);
  assign seq1_eos  = eos1_q;
  assign seq2_eos  = eos2_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !adc_done) |=> (req_q && $stable(adc_chan))); // R12
  AST_SIM_TOPBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && cfg_simul) |-> !adc_chan[CH_W-1]); // R4
  AST_EOS_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (eos1_q || eos2_q) |-> $past(conv_fire)); // R10
  AST_CASC_NO_SEQ2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cascade && idle) |=> owner_q != OWN_S2); // R8
endmodule

// File: tb/adc_dual_seq_bench.sv
module adc_dual_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  typedef struct packed {
    logic       casc;
    logic       simul;
    logic [3:0] cnt1;
    logic [2:0] cnt2;
    logic       ta;
    logic       tb;
    logic       clr1;
    logic       clr2;
    logic [3:0] ep1;
    logic [2:0] ep2;
    logic [1:0] ee1;
    logic [1:0] ee2;
  } vec_t;

  // stimulus and expected pointers / end-of-run counts
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,4'd3,3'd1,1'b1,1'b0,1'b0,1'b0,4'd4, 3'd0,2'd1,2'd0},
    '{1'b0,1'b0,4'd3,3'd1,1'b1,1'b0,1'b0,1'b0,4'd0, 3'd0,2'd1,2'd0},
    '{1'b0,1'b0,4'd0,3'd2,1'b0,1'b1,1'b0,1'b0,4'd0, 3'd3,2'd0,2'd1},
    '{1'b0,1'b1,4'd1,3'd1,1'b1,1'b1,1'b0,1'b0,4'd2, 3'd5,2'd1,2'd1},
    '{1'b0,1'b1,4'd0,3'd0,1'b0,1'b1,1'b0,1'b1,4'd2, 3'd1,2'd0,2'd1},
    '{1'b1,1'b0,4'd9,3'd0,1'b1,1'b1,1'b0,1'b0,4'd12,3'd1,2'd1,2'd0},
    '{1'b1,1'b1,4'd5,3'd0,1'b1,1'b1,1'b0,1'b0,4'd2, 3'd1,2'd1,2'd0},
    '{1'b0,1'b0,4'd7,3'd0,1'b1,1'b0,1'b1,1'b0,4'd0, 3'd1,2'd1,2'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_cascade = 0, cfg_simul = 0, cfg_contin = 0, cfg_trig_a_en = 1, cfg_trig_b_en = 1;
  logic [3:0] cfg_cnt1 = '0;
  logic [2:0] cfg_cnt2 = '0;
  logic [63:0] cfg_slots;
  logic trig_a = 0, trig_b = 0, ptr_clr1 = 0, ptr_clr2 = 0;
  logic adc_req, adc_done = 1'b0;
  logic [3:0] adc_chan;
  logic [11:0] adc_code_a, adc_code_b;
  logic [191:0] results;
  logic [3:0] seq1_ptr;
  logic [2:0] seq2_ptr;
  logic seq1_busy, seq2_busy, seq1_eos, seq2_eos;

  int n_chk = 0, n_bad = 0;
  int eos1_cnt = 0, eos2_cnt = 0, eos_dbl = 0, hs_bad = 0;
  logic [11:0] exp_res [16];
  int m_p1 = 0, m_p2 = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_dual_seq u_adc_dual_seq (
    .clk(clk), .rst_n(rst_n), .cfg_cascade(cfg_cascade), .cfg_simul(cfg_simul),
    .cfg_contin(cfg_contin), .cfg_trig_a_en(cfg_trig_a_en), .cfg_trig_b_en(cfg_trig_b_en),
    .cfg_cnt1(cfg_cnt1), .cfg_cnt2(cfg_cnt2), .cfg_slots(cfg_slots),
    .trig_a(trig_a), .trig_b(trig_b), .ptr_clr1(ptr_clr1), .ptr_clr2(ptr_clr2),
    .adc_req(adc_req), .adc_chan(adc_chan), .adc_done(adc_done),
    .adc_code_a(adc_code_a), .adc_code_b(adc_code_b), .results(results),
    .seq1_ptr(seq1_ptr), .seq2_ptr(seq2_ptr), .seq1_busy(seq1_busy),
    .seq2_busy(seq2_busy), .seq1_eos(seq1_eos), .seq2_eos(seq2_eos)
  );

  function automatic logic [3:0] bsel(input int k);
    return 4'((k * 7 + 5) & 15);
  endfunction

  // converter model: code carries the side and the pair number
  assign adc_code_a = 12'hA00 | {9'd0, adc_chan[2:0]};
  assign adc_code_b = 12'hB00 | {9'd0, adc_chan[2:0]};

  int dcnt = 0;
  always @(negedge clk) begin
    if (!adc_req) begin
      adc_done <= 1'b0; dcnt = 0;
    end else if (dcnt == 2) begin
      adc_done <= 1'b1; dcnt = 0;
    end else begin
      adc_done <= 1'b0; dcnt++;
    end
  end

  // monitors: end-of-run pulses and handshake stability (R10, R12)
  logic e1p = 0, e2p = 0, reqp = 0;
  logic [3:0] chp = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (seq1_eos) eos1_cnt++;
      if (seq2_eos) eos2_cnt++;
      if ((seq1_eos && e1p) || (seq2_eos && e2p)) eos_dbl++;
      if (reqp && !adc_done && (!adc_req || adc_chan != chp)) hs_bad++;
    end
    e1p = seq1_eos; e2p = seq2_eos; reqp = adc_req; chp = adc_chan;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_bank(input string req);
    int bad_i;
    bad_i = -1;
    for (int i = 15; i >= 0; i--)
      if (results[i*12 +: 12] !== exp_res[i]) bad_i = i;
    n_chk++;
    if (bad_i >= 0) begin
      n_bad++;
      $display("FAIL %s: result[%0d] actual %h expected %h", req, bad_i,
               results[bad_i*12 +: 12], exp_res[bad_i]);
    end
  endtask

  function automatic logic [11:0] code_for(input logic [3:0] s, input bit side_b, input bit simul);
    if (simul) return (side_b ? 12'hB00 : 12'hA00) | {9'd0, s[2:0]};
    return (s[3] ? 12'hB00 : 12'hA00) | {9'd0, s[2:0]};
  endfunction

  task automatic model_s1(input bit casc, input bit simul, input int cnt);
    for (int n = 0; n <= cnt; n++) begin
      int slot;
      slot = casc ? m_p1 : (m_p1 % 8);
      if (simul) begin
        exp_res[(2*slot) % 16]     = code_for(bsel(slot), 0, 1);
        exp_res[(2*slot) % 16 + 1] = code_for(bsel(slot), 1, 1);
      end else exp_res[slot] = code_for(bsel(slot), 0, 0);
      m_p1 = casc ? (m_p1 + 1) % 16 : ((m_p1 % 8) + 1) % 8;
    end
  endtask

  task automatic model_s2(input bit simul, input int cnt);
    for (int n = 0; n <= cnt; n++) begin
      int slot;
      slot = 8 + m_p2;
      if (simul) begin
        exp_res[(8 + 2*m_p2) % 16]     = code_for(bsel(slot), 0, 1);
        exp_res[(8 + 2*m_p2) % 16 + 1] = code_for(bsel(slot), 1, 1);
      end else exp_res[slot] = code_for(bsel(slot), 0, 0);
      m_p2 = (m_p2 + 1) % 8;
    end
  endtask

  task automatic pulse_trig(input bit a, input bit b);
    @(negedge clk); trig_a = a; trig_b = b;
    @(negedge clk); trig_a = 0; trig_b = 0;
  endtask

  task automatic pulse_clr(input bit c1, input bit c2);
    @(negedge clk); ptr_clr1 = c1; ptr_clr2 = c2;
    @(negedge clk); ptr_clr1 = 0; ptr_clr2 = 0;
  endtask

  task automatic wait_idle();
    int quiet;
    quiet = 0;
    repeat (3) @(negedge clk);
    while (quiet < 3) begin
      @(negedge clk);
      if (!seq1_busy && !seq2_busy) quiet++; else quiet = 0;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 16; k++) begin
      cfg_slots[k*4 +: 4] = bsel(k);
      exp_res[k] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 req", int'(adc_req), 0);
    check("R1 ptr1", int'(seq1_ptr), 0);
    check("R1 ptr2", int'(seq2_ptr), 0);
    check("R1 busy/eos", int'({seq1_busy, seq2_busy, seq1_eos, seq2_eos}), 0);
    check_bank("R1 results");

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      int e1, e2;
      t = TBL[v];
      @(negedge clk);
      cfg_cascade = t.casc; cfg_simul = t.simul;
      cfg_cnt1 = t.cnt1; cfg_cnt2 = t.cnt2;
      if (t.clr1 || t.clr2) pulse_clr(t.clr1, t.clr2);
      if (t.clr1) m_p1 = 0;
      if (t.clr2) m_p2 = 0;
      e1 = eos1_cnt; e2 = eos2_cnt;
      pulse_trig(t.ta, t.tb);
      wait_idle();
      if (t.ta) model_s1(t.casc, t.simul, int'(t.cnt1));
      if (t.tb && !t.casc) model_s2(t.simul, int'(t.cnt2));
      check($sformatf("R5 R8 ptr1 vec%0d", v), int'(seq1_ptr), int'(t.ep1));
      check($sformatf("R2 R6 ptr2 vec%0d", v), int'(seq2_ptr), int'(t.ep2));
      check($sformatf("R10 eos1 vec%0d", v), eos1_cnt - e1, int'(t.ee1));
      check($sformatf("R7 eos2 vec%0d", v), eos2_cnt - e2, int'(t.ee2));
      check_bank($sformatf("R3 R4 R9 bank vec%0d", v));
    end

    // R7: disabled trigger does nothing
    begin
      int e1;
      cfg_cascade = 0; cfg_simul = 0; cfg_cnt1 = 4'd2; cfg_trig_a_en = 0;
      e1 = eos1_cnt;
      pulse_trig(1, 0);
      wait_idle();
      check("R7 disabled ptr1", int'(seq1_ptr), m_p1);
      check("R7 disabled eos1", eos1_cnt - e1, 0);
      check_bank("R7 disabled bank");
      cfg_trig_a_en = 1;
    end

    // R9: second trigger during a busy run is held and served
    begin
      int e1;
      e1 = eos1_cnt;
      pulse_trig(1, 0);
      @(negedge clk);
      pulse_trig(1, 0);
      wait_idle();
      model_s1(0, 0, 2);
      model_s1(0, 0, 2);
      check("R9 pending ptr1", int'(seq1_ptr), 6);
      check("R9 pending eos1", eos1_cnt - e1, 2);
      check_bank("R9 pending bank");
    end

    // R11: continuous mode restarts from slot 0
    begin
      int e1;
      pulse_clr(1, 0);
      m_p1 = 0;
      cfg_cnt1 = 4'd1; cfg_contin = 1;
      e1 = eos1_cnt;
      pulse_trig(1, 0);
      repeat (40) @(negedge clk);
      check("R11 still busy", int'(seq1_busy), 1);
      check("R11 several runs", int'(eos1_cnt - e1 >= 3), 1);
      cfg_contin = 0;
      wait_idle();
      model_s1(0, 0, 1);
      check("R11 stop ptr1", int'(seq1_ptr), 2);
      check_bank("R11 bank");
    end

    check("R10 eos single-cycle", eos_dbl, 0);
    check("R12 handshake stable", hs_bad, 0);
    finish_run();
  end
endmodule